// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This unit moves vector elements between a source and a destination register under a per-element mask. It works one element per clock. In **compress** mode it walks the source in order and writes each element whose mask bit is set to the next free slot of the destination, starting at slot 0. In **expand** mode it works the other way: it takes source elements from slot 0 upward and drops each one at the next destination position whose mask bit is set. The unit also reports the number of active mask bits, which is the length of the packed vector.

The unit drives a source read index and reads back the element data combinationally in the same cycle. It drives a single destination write port with an enable. A destination position is left untouched when no write is issued to it. A one-cycle `start_i` pulse launches an operation. `busy_o` covers the element cycles, and `done_o` pulses once at the end. The caller must keep `vl_i` at or below the register length `VLMAX`.

Top module: `vmask_cmpx`

## Requirements
- R1: With `op_i`=0 (compress), the source element at index i is written to destination index k when mask bit i is set, where k is the number of set mask bits below i. Relative order is kept and the writes start at index 0.
- R2: From the cycle after a start is accepted, `packed_len_o` equals the number of set mask bits at indices below `vl_i`. It holds that value until the next accepted start.
- R3: With `op_i`=1 (expand), the k-th source element (k counted from 0) is written to the destination index of the k-th set mask bit.
- R4: During expand, no write is issued to a destination position whose mask bit is clear, so that position keeps its previous value.
- R5: During compress, no write is issued to a destination index at or above the packed length.
- R6: Mask bits at index `vl_i` and above have no effect on writes or on the packed length.
- R7: An operation of length vl keeps `busy_o` high for exactly vl cycles and handles element i in the i-th of them. `done_o` is a one-cycle pulse in the cycle after the last element. With vl=0, `done_o` pulses in the cycle right after the start.
- R8: An all-zero active mask gives a packed length of 0 and no destination writes.
- R9: A `start_i` that arrives while `busy_o` is high is ignored, and the running operation continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launches an operation when idle |
| op_i | input | 1 | 0 = compress, 1 = expand |
| vl_i | input | $clog2(VLMAX+1) | Active vector length (at most VLMAX) |
| mask_i | input | VLMAX | Per-element mask, bit i for element i |
| src_rd_idx_o | output | $clog2(VLMAX) | Source element being read |
| src_rd_data_i | input | EW | Source element data for `src_rd_idx_o` |
| dst_wr_en_o | output | 1 | Destination write enable |
| dst_wr_idx_o | output | $clog2(VLMAX) | Destination element index |
| dst_wr_data_o | output | EW | Destination element data |
| busy_o | output | 1 | Element processing in progress |
| done_o | output | 1 | One-cycle completion pulse |
| packed_len_o | output | $clog2(VLMAX+1) | Population count of the active mask |

## Verification
A corrupted packed-slot counter shows up at the write port at the first set mask bit that follows the corruption. In compress mode it appears as a wrong write index. In expand mode it appears as a wrong source read index, and the bench sees it in the same cycle as a data mismatch. A fault in the latched mask or in the length clipping shows up within one element cycle, either as a write that should not happen or as a missing write. The bench also catches it at completion, through `packed_len_o` and through a full compare of the destination contents. A fault in the element counter or the end detection changes the number of busy cycles, so the `done_o` pulse lands a cycle early or late.

// File: rtl/vmx_pkg.sv
// Shared definitions for the vector mask compress/expand unit.
package vmx_pkg;
    // Operation selector: pack set-mask elements, or spread them back out.
    typedef enum logic {
        OP_PACK   = 1'b0,
        OP_SPREAD = 1'b1
    } vmx_op_e;
endpackage

// File: rtl/vmx_popcount.sv
// Counts set bits of a mask vector.
// Assumes: purely combinational; N is small enough for a linear sum.
module vmx_popcount #(
    parameter int N  = 16,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits_i,
    output logic [CW-1:0] count_o
);
    // Sum the bits one by one.
    always_comb begin
        count_o = '0;
        for (int j = 0; j < N; j++) begin
            count_o = count_o + CW'(bits_i[j]);
        end
    end
endmodule

// File: rtl/vmx_seq.sv
// Sequencer: accepts a start while idle, latches the operation, steps an
// element counter once per cycle and pulses done after the last element.
// Assumes: vl_i <= VLMAX; mask_i is already clipped to the active length.
module vmx_seq #(
    parameter int VLMAX = 16,
    localparam int IW = $clog2(VLMAX),
    localparam int LW = $clog2(VLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             op_i,
    input  logic [LW-1:0]    vl_i,
    input  logic [VLMAX-1:0] mask_i,
    input  logic [LW-1:0]    popcnt_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [IW-1:0]    elem_idx_o,
    output logic             op_o,
    output logic             mask_bit_o,
    output logic [LW-1:0]    packed_len_o
);
    logic [VLMAX-1:0] mask_q;
    logic [LW-1:0]    vl_q;
    logic             last_elem;

    // A start is taken only when no operation is running.
    assign accept_o   = start_i && !busy_o;
    assign last_elem  = (LW'(elem_idx_o) + LW'(1)) == vl_q;
    assign mask_bit_o = mask_q[elem_idx_o];

    // Operation state: latch on accept, step while busy, pulse done at end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q       <= '0;
            vl_q         <= '0;
            op_o         <= 1'b0;
            busy_o       <= 1'b0;
            done_o       <= 1'b0;
            elem_idx_o   <= '0;
            packed_len_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (accept_o) begin
                mask_q       <= mask_i;
                vl_q         <= vl_i;
                op_o         <= op_i;
                packed_len_o <= popcnt_i;
                elem_idx_o   <= '0;
                if (vl_i == '0) done_o <= 1'b1;
                else            busy_o <= 1'b1;
            end else if (busy_o) begin
                if (last_elem) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    elem_idx_o <= elem_idx_o + IW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/vmx_route.sv
// Router: keeps the packed-slot counter and maps the element counter and
// packed-slot counter onto source read and destination write indices.
// Assumes: source data returns combinationally for src_idx_o.
module vmx_route #(
    parameter int VLMAX = 16,
    parameter int EW    = 16,
    localparam int IW = $clog2(VLMAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          busy_i,
    input  logic          op_i,
    input  logic          mask_bit_i,
    input  logic [IW-1:0] elem_idx_i,
    input  logic [EW-1:0] src_data_i,
    output logic [IW-1:0] src_idx_o,
    output logic          wr_en_o,
    output logic [IW-1:0] wr_idx_o,
    output logic [EW-1:0] wr_data_o
);
    import vmx_pkg::*;

    logic [IW-1:0] slot_q;
    logic          spread;

    assign spread = (vmx_op_e'(op_i) == OP_SPREAD);

    // Packed-slot counter: restarts on accept, advances on each active element.
    always_ff @(posedge clk) begin
        if (!rst_n)                     slot_q <= '0;
        else if (clear_i)               slot_q <= '0;
        else if (busy_i && mask_bit_i)  slot_q <= slot_q + IW'(1);
    end

    // Index mapping: the packed side is the slot counter, the sparse side is the element counter.
    always_comb begin
        src_idx_o = spread ? slot_q : elem_idx_i;
        wr_idx_o  = spread ? elem_idx_i : slot_q;
        wr_en_o   = busy_i && mask_bit_i;
        wr_data_o = src_data_i;
    end
endmodule

// File: rtl/vmask_cmpx.sv
// Top: vector mask compress/expand unit. Clips the mask to the active
// length, counts it, and drives one element per cycle through the router.
// Assumes: vl_i <= VLMAX; one-cycle combinational source read.
module vmask_cmpx #(
    parameter int VLMAX = 16,
    parameter int EW    = 16,
    localparam int IW = $clog2(VLMAX),
    localparam int LW = $clog2(VLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             op_i,
    input  logic [LW-1:0]    vl_i,
    input  logic [VLMAX-1:0] mask_i,
    output logic [IW-1:0]    src_rd_idx_o,
    input  logic [EW-1:0]    src_rd_data_i,
    output logic             dst_wr_en_o,
    output logic [IW-1:0]    dst_wr_idx_o,
    output logic [EW-1:0]    dst_wr_data_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [LW-1:0]    packed_len_o
);
    logic [VLMAX-1:0] mask_clip;
    logic [LW-1:0]    popcnt;
    logic             accept;
    logic [IW-1:0]    elem_idx;
    logic             op_q;
    logic             mask_bit;

    // Drop mask bits at or beyond the active length.
    always_comb begin
        for (int j = 0; j < VLMAX; j++) begin
            mask_clip[j] = mask_i[j] && (j < int'(vl_i));
        end
    end

    vmx_popcount #(.N(VLMAX)) u_pop (
        .bits_i  (mask_clip),
        .count_o (popcnt)
    );

    vmx_seq #(.VLMAX(VLMAX)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .op_i         (op_i),
        .vl_i         (vl_i),
        .mask_i       (mask_clip),
        .popcnt_i     (popcnt),
        .accept_o     (accept),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .elem_idx_o   (elem_idx),
        .op_o         (op_q),
        .mask_bit_o   (mask_bit),
        .packed_len_o (packed_len_o)
    );

    vmx_route #(.VLMAX(VLMAX), .EW(EW)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (accept),
        .busy_i     (busy_o),
        .op_i       (op_q),
        .mask_bit_i (mask_bit),
        .elem_idx_i (elem_idx),
        .src_data_i (src_rd_data_i),
        .src_idx_o  (src_rd_idx_o),
        .wr_en_o    (dst_wr_en_o),
        .wr_idx_o   (dst_wr_idx_o),
        .wr_data_o  (dst_wr_data_o)
    );
endmodule

// File: rtl/vmx_chk.sv
// Checker for the compress/expand unit, bound onto the top module.
module vmx_chk #(
    parameter int VLMAX = 16,
    localparam int IW = $clog2(VLMAX),
    localparam int LW = $clog2(VLMAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          wr_en,
    input logic [IW-1:0] wr_idx,
    input logic [IW-1:0] src_idx,
    input logic          op_q,
    input logic [LW-1:0] packed_len
);
    // R7: writes occur only during element cycles.
    assert_write_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);
    // R7: done is a single-cycle pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: the end of the busy window is marked by done.
    assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R5: compress never writes at or above the packed length.
    assert_pack_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !op_q) |-> (LW'(wr_idx) < packed_len));
    // R1: compress destination never runs ahead of the source element.
    assert_pack_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !op_q) |-> (wr_idx <= src_idx));
    // R3: expand source never runs ahead of the destination position.
    assert_spread_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_q) |-> (src_idx <= wr_idx));
    // R2: packed length stays fixed across an operation.
    assert_len_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(packed_len));
    // R8: a zero packed length means no writes.
    assert_zero_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && packed_len == '0) |-> !wr_en);
endmodule

bind vmask_cmpx vmx_chk #(.VLMAX(VLMAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy_o),
    .done       (done_o),
    .wr_en      (dst_wr_en_o),
    .wr_idx     (dst_wr_idx_o),
    .src_idx    (src_rd_idx_o),
    .op_q       (op_q),
    .packed_len (packed_len_o)
);

// File: tb/tb_vmask_cmpx.sv
module tb_vmask_cmpx;
    localparam int VLMAX = 16;
    localparam int EW    = 16;
    localparam int IW    = $clog2(VLMAX);
    localparam int LW    = $clog2(VLMAX + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             op_i = 1'b0;
    logic [LW-1:0]    vl_i = '0;
    logic [VLMAX-1:0] mask_i = '0;
    logic [IW-1:0]    src_rd_idx_o;
    logic [EW-1:0]    src_rd_data_i;
    logic             dst_wr_en_o;
    logic [IW-1:0]    dst_wr_idx_o;
    logic [EW-1:0]    dst_wr_data_o;
    logic             busy_o;
    logic             done_o;
    logic [LW-1:0]    packed_len_o;

    logic [EW-1:0] src_mem [VLMAX];
    logic [EW-1:0] dst_mem [VLMAX];
    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    vmask_cmpx #(.VLMAX(VLMAX), .EW(EW)) dut (.*);

    assign src_rd_data_i = src_mem[src_rd_idx_o];

    // Destination register model: preset on reset, written by the unit.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < VLMAX; i++) dst_mem[i] <= EW'(16'hD000 + i);
        end else if (dst_wr_en_o) begin
            dst_mem[dst_wr_idx_o] <= dst_wr_data_o;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R7 watchdog: actual %0d expected %0d", cyc, 20000);
                finish_run();
            end
        end
    end

    // One operation against a behavioural model; poke re-drives start while busy.
    task automatic run(input bit op, input int vl, input logic [VLMAX-1:0] mask, input bit poke);
        logic [EW-1:0] exp_dst [VLMAX];
        bit            q_en[$];
        int            q_idx[$];
        logic [EW-1:0] q_dat[$];
        int k = 0;
        string rq = op ? "R3" : "R1";
        for (int i = 0; i < VLMAX; i++) exp_dst[i] = dst_mem[i];
        for (int c = 0; c < vl; c++) begin
            if (mask[c]) begin
                q_en.push_back(1'b1);
                q_idx.push_back(op ? c : k);
                q_dat.push_back(op ? src_mem[k] : src_mem[c]);
                if (op) exp_dst[c] = src_mem[k]; else exp_dst[k] = src_mem[c];
                k++;
            end else begin
                q_en.push_back(1'b0);
                q_idx.push_back(0);
                q_dat.push_back('0);
            end
        end
        @(negedge clk);
        start_i = 1'b1; op_i = op; vl_i = LW'(vl); mask_i = mask;
        @(posedge clk); #1;
        if (poke) begin
            op_i = ~op; vl_i = LW'(3); mask_i = '1;
        end else begin
            start_i = 1'b0;
        end
        for (int c = 0; c < vl; c++) begin
            bit e; int ix; logic [EW-1:0] d;
            @(negedge clk);
            if (poke && c == vl - 1) start_i = 1'b0;
            e = q_en.pop_front(); ix = q_idx.pop_front(); d = q_dat.pop_front();
            chk(poke ? "R9" : "R7", "busy", busy_o, 1);
            chk(op ? "R4" : "R1", "wr_en", dst_wr_en_o, e);
            if (e) begin
                chk(rq, "wr_idx", dst_wr_idx_o, ix);
                chk(rq, "wr_data", dst_wr_data_o, d);
            end
        end
        @(negedge clk);
        if (poke) start_i = 1'b0;
        chk("R7", "done", done_o, 1);
        chk("R7", "busy_end", busy_o, 0);
        chk("R2", "packed_len", packed_len_o, k);
        for (int i = 0; i < VLMAX; i++)
            chk(op ? "R4" : "R5", "dst", dst_mem[i], exp_dst[i]);
        @(negedge clk);
        chk("R7", "done_drop", done_o, 0);
        chk("R2", "len_hold", packed_len_o, k);
    endtask

    initial begin
        for (int i = 0; i < VLMAX; i++) src_mem[i] = EW'(16'hA100 + 16'h11 * i);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R7", "reset_busy", busy_o, 0);
        chk("R7", "reset_done", done_o, 0);
        chk("R2", "reset_len", packed_len_o, 0);
        // R1: compress with a scattered mask
        run(1'b0, 16, 16'b1011_0010_0110_1001, 1'b0);
        // R3 / R4: expand with a scattered mask
        run(1'b1, 16, 16'b0101_1100_1001_0010, 1'b0);
        // R6: mask bits beyond the active length ignored
        run(1'b0, 5, 16'hFFE5, 1'b0);
        run(1'b1, 5, 16'hFFE5, 1'b0);
        // R8: all-zero active mask
        run(1'b0, 9, 16'hFE00, 1'b0);
        run(1'b1, 16, 16'h0000, 1'b0);
        // R7: zero length and single element
        run(1'b0, 0, 16'hFFFF, 1'b0);
        run(1'b1, 1, 16'h0001, 1'b0);
        // R3: full mask expand, R1: full mask compress
        run(1'b1, 16, 16'hFFFF, 1'b0);
        run(1'b0, 16, 16'hFFFF, 1'b0);
        // R9: start held high while busy
        run(1'b0, 12, 16'h0A5C, 1'b1);
        run(1'b1, 10, 16'h0333, 1'b1);
        // Mixed patterns
        for (int t = 0; t < 24; t++) begin
            for (int i = 0; i < VLMAX; i++) src_mem[i] = EW'($urandom);
            run(t[0], int'($urandom_range(0, VLMAX)), VLMAX'($urandom), 1'b0);
        end
        finish_run();
    end
endmodule